// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is a serial slave that sits in front of a small byte-wide memory array and makes it behave like a serial EEPROM. The host selects the block with `cs_n`, shifts an 8-bit instruction in on `si`, followed by an address or a data byte where the instruction needs one, and collects reply bits from `so`. Instructions let the host set and clear a write-enable latch, read and write a status byte, read the array sequentially and load up to one page of bytes for programming.

Programming is self-timed. Data bytes collect in a page buffer. When `cs_n` rises after a complete byte, and every permission holds, a program cycle starts. It runs for a set number of clock cycles, and the host polls a busy bit in the status byte until it clears. Two status bits protect a region of the array. The active-low `wp_n` input blocks every kind of programming. The active-low `hold_n` input freezes the serial stream in mid-transfer.

All serial pins are sampled on the system clock `clk`. The clock must run several times faster than `sck`.

Top module: `spi_ee_ctrl`

## Requirements
- R1: The bus runs in mode 0. `si` is taken on each rising `sck` edge, and `so` changes only after a falling `sck` edge. Bytes go most significant bit first.
- R2: `so_en` is high exactly when, on the previous clock, `cs_n` was low and `hold_n` was high. At all other times `so` is to be treated as released.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R4: Opcode 0x02 is followed by a 16-bit address, sent high byte first, and then data. Address bits at and above `ADDR_W` are ignored. With the write-enable latch clear, the write has no effect on the array.
- R5: If `wp_n` is low when `cs_n` rises, a pending page write or status write is discarded and no program cycle starts.
- R6: Status bits [3:2] protect part of the array. 00 protects nothing, 01 the upper quarter, 10 the upper half and 11 the whole array. A write aimed at a protected page is discarded and leaves the write-enable latch set.
- R7: Within one write, consecutive data bytes go to consecutive addresses. Only the low 5 address bits advance, so the bytes wrap inside the same 32-byte page.
- R8: A program cycle raises busy on the clock after `cs_n` rises. Busy stays high for `PROG_CYCLES` clocks. The array or the status bits are updated during this window, and the write-enable latch is clear when busy falls.
- R9: While busy is high, every instruction except 0x05 is ignored. A read issued then returns zero bytes, and a write-enable issued then does not set the latch.
- R10: Opcode 0x03 with a 16-bit address returns one byte per further 8 clocks from successive addresses. Reading wraps from the last address to address 0 for as long as `cs_n` stays low.
- R11: While `hold_n` is low, `sck` edges are ignored and `so_en` is low. The bit position and `so` are unchanged when `hold_n` returns high.
- R12: A program cycle starts only when at least one data byte was received and the number of bits after the instruction is a multiple of 8.
- R13: Opcode 0x05 returns the status byte on every following byte of the transfer. Bit 0 is busy, bit 1 is the write-enable latch, bits [3:2] are the protect code and the other bits read 0. After reset the status byte is 0x00.
- R14: Opcode 0x01 takes one data byte. Its bits [3:2] become the protect code at the end of a program cycle. That cycle needs the same latch and `wp_n` conditions as a page write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pauses the transfer while low |
| wp_n | input | 1 | Blocks all programming while low |
| so | output | 1 | Serial data to the host |
| so_en | output | 1 | High while `so` is being driven |

## Verification
The main function is exercised with several kinds of transfer:
- Plain and page-wrapping writes.
- Reads that start at an offset, that carry garbage in the ignored upper address bits, or that run past the top of the array.
- Writes with the latch clear, with `wp_n` low, into each protected region, truncated by three bits, and issued while busy.

Comparing each read-back with the reference array separates a wrong address counter, a missing page wrap and a skipped permission check. Polling the status byte right after each transfer and again after the program window separates a cycle that starts from one that was correctly discarded. It also shows whether the latch clears at the end of the cycle or at the start. A hold inserted in the middle of a read byte tells a frozen bit counter apart from one that kept counting.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OP_SETSR = 8'h01;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_FETCH = 8'h03;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_GETSR = 8'h05;
    localparam logic [7:0] OP_WENA  = 8'h06;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_AHI,
        PH_ALO,
        PH_DATA,
        PH_STAT,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic [1:0] prot;
        logic       wel;
        logic       busy;
    } status_t;

    function automatic logic [7:0] status_byte(status_t s);
        return {4'b0000, s.prot, s.wel, s.busy};
    endfunction

    // top2 = two most significant address bits of the target page
    function automatic logic region_locked(logic [1:0] prot, logic [1:0] top2);
        case (prot)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_ee_shift.sv
module spi_ee_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       rise,
    input  logic       fall,
    input  logic       si,
    input  logic       load,
    input  logic [7:0] load_val,
    output logic [7:0] rx_byte,
    output logic       rx_done,
    output logic [2:0] bit_cnt,
    output logic       so_bit
);
    logic [6:0] sh;
    logic [7:0] tx;

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            bit_cnt <= '0;
            sh      <= '0;
            tx      <= '0;
            so_bit  <= 1'b0;
        end else begin
            if (rise) begin
                sh      <= {sh[5:0], si};
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (load) begin
                tx <= load_val;
            end else if (fall) begin
                so_bit <= tx[7];
                tx     <= {tx[6:0], 1'b0};
            end
        end
    end

    assign rx_done = rise && (bit_cnt == 3'd7);
    assign rx_byte = {sh, si};
endmodule

// File: rtl/spi_ee_prog.sv
module spi_ee_prog #(
    parameter int AW          = 11,
    parameter int PAGE_W      = 5,
    parameter int PROG_CYCLES = 1000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 bwe,
    input  logic [PAGE_W-1:0]    bidx,
    input  logic [7:0]           bdata,
    input  logic                 go_page,
    input  logic                 go_stat,
    input  logic [AW-PAGE_W-1:0] page_addr,
    output logic                 busy,
    output logic                 done,
    output logic                 is_stat,
    output logic                 mwe,
    output logic [AW-1:0]        maddr,
    output logic [7:0]           mdata
);
    localparam int PAGE = 1 << PAGE_W;
    localparam int CW   = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

    logic [7:0]           pbuf [PAGE];
    logic [PAGE-1:0]      valid;
    logic [CW-1:0]        cyc;
    logic [AW-PAGE_W-1:0] pg;
    logic [PAGE_W-1:0]    idx;

    always_ff @(posedge clk) begin
        if (bwe) pbuf[bidx] <= bdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  valid <= '0;
        else if (bwe)    valid[bidx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cyc     <= '0;
            is_stat <= 1'b0;
            pg      <= '0;
        end else if (!busy) begin
            if (go_page || go_stat) begin
                busy    <= 1'b1;
                cyc     <= '0;
                is_stat <= go_stat;
                pg      <= page_addr;
            end
        end else begin
            if (cyc == LAST) busy <= 1'b0;
            cyc <= cyc + 1'b1;
        end
    end

    // commit one buffered byte per clock at the start of the window
    assign idx   = cyc[PAGE_W-1:0];
    assign done  = busy && (cyc == LAST);
    assign mwe   = busy && !is_stat && (cyc < CW'(PAGE)) && valid[idx];
    assign maddr = {pg, idx};
    assign mdata = pbuf[idx];
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_en
);
    logic              sck_d, cs_d, sel, rise, fall, cs_up;
    logic [7:0]        rx_byte, load_val, rd_data, mdata;
    logic              rx_done, load, so_bit;
    logic [2:0]        bit_cnt;
    phase_e            phase;
    logic [7:0]        op;
    logic [ADDR_W-9:0] addr_hi;
    logic [ADDR_W-1:0] addr, rd_a, maddr;
    logic              wel, busy, done, is_stat, mwe, clr, bwe, data_seen;
    logic [1:0]        prot, prot_pend;
    logic              go_page, go_stat, perm;
    status_t           st;

    assign sel   = !cs_n;
    assign rise  = sel && hold_n && sck && !sck_d;
    assign fall  = sel && hold_n && !sck && sck_d;
    assign cs_up = cs_n && !cs_d;
    assign st    = '{prot: prot, wel: wel, busy: busy};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
            so_en <= 1'b0;
        end else begin
            sck_d <= sck;
            cs_d  <= cs_n;
            so_en <= sel && hold_n;
        end
    end

    spi_ee_shift u_shift (
        .clk(clk), .rst(rst), .sel(sel), .rise(rise), .fall(fall), .si(si),
        .load(load), .load_val(load_val), .rx_byte(rx_byte), .rx_done(rx_done),
        .bit_cnt(bit_cnt), .so_bit(so_bit)
    );

    always_comb begin
        load     = 1'b0;
        load_val = rd_data;
        bwe      = 1'b0;
        clr      = 1'b0;
        rd_a     = addr;
        if (rx_done) begin
            case (phase)
                PH_CMD: begin
                    if (rx_byte == OP_GETSR) begin
                        load     = 1'b1;
                        load_val = status_byte(st);
                    end
                end
                PH_ALO: begin
                    rd_a = {addr_hi, rx_byte};
                    load = (op == OP_FETCH);
                    clr  = (op == OP_PROG);
                end
                PH_DATA: begin
                    load = (op == OP_FETCH);
                    bwe  = (op == OP_PROG);
                end
                PH_STAT: begin
                    load     = 1'b1;
                    load_val = status_byte(st);
                end
                default: ;
            endcase
        end
    end

    assign perm    = cs_up && (phase == PH_DATA) && data_seen && (bit_cnt == 3'd0)
                     && wel && wp_n && !busy;
    assign go_page = perm && (op == OP_PROG)
                     && !region_locked(prot, addr[ADDR_W-1 -: 2]);
    assign go_stat = perm && (op == OP_SETSR);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_CMD;
            op        <= '0;
            addr_hi   <= '0;
            addr      <= '0;
            wel       <= 1'b0;
            prot      <= 2'b00;
            prot_pend <= 2'b00;
            data_seen <= 1'b0;
        end else begin
            if (done) begin
                wel <= 1'b0;
                if (is_stat) prot <= prot_pend;
            end
            if (!sel) begin
                phase     <= PH_CMD;
                data_seen <= 1'b0;
            end else if (rx_done) begin
                case (phase)
                    PH_CMD: begin
                        phase <= PH_SKIP;
                        case (rx_byte)
                            OP_WENA:  if (!busy) wel <= 1'b1;
                            OP_WDIS:  if (!busy) wel <= 1'b0;
                            OP_GETSR: phase <= PH_STAT;
                            OP_SETSR: if (!busy) begin
                                phase <= PH_DATA;
                                op    <= rx_byte;
                            end
                            OP_FETCH, OP_PROG: if (!busy) begin
                                phase <= PH_AHI;
                                op    <= rx_byte;
                            end
                            default: ;
                        endcase
                    end
                    PH_AHI: begin
                        addr_hi <= rx_byte[ADDR_W-9:0];
                        phase   <= PH_ALO;
                    end
                    PH_ALO: begin
                        addr  <= (op == OP_FETCH) ? rd_a + 1'b1 : rd_a;
                        phase <= PH_DATA;
                    end
                    PH_DATA: begin
                        data_seen <= 1'b1;
                        if (op == OP_FETCH) addr <= addr + 1'b1;
                        if (op == OP_PROG)  addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
                        if (op == OP_SETSR) prot_pend <= rx_byte[3:2];
                    end
                    default: ;
                endcase
            end
        end
    end

    spi_ee_prog #(.AW(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
        .clk(clk), .rst(rst), .clr(clr), .bwe(bwe), .bidx(addr[PAGE_W-1:0]),
        .bdata(rx_byte), .go_page(go_page), .go_stat(go_stat),
        .page_addr(addr[ADDR_W-1:PAGE_W]), .busy(busy), .done(done),
        .is_stat(is_stat), .mwe(mwe), .maddr(maddr), .mdata(mdata)
    );

    spi_ee_array #(.AW(ADDR_W), .DW(8)) u_array (
        .clk(clk), .we(mwe), .waddr(maddr), .wdata(mdata),
        .raddr(rd_a), .rdata(rd_data)
    );

    assign so = so_bit;
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker #(
    parameter int PROG_CYCLES = 1000
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sck,
    input logic       hold_n,
    input logic       wp_n,
    input logic       so,
    input logic       sck_d,
    input logic [2:0] bit_cnt,
    input logic       busy,
    input logic       wel
);
    int busy_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_len <= 0;
        else              busy_len <= busy_len + 1;
    end

    // R1: the data output moves only on a falling serial clock
    a_r1_so_after_fall: assert property (@(posedge clk) disable iff (rst)
        (!$stable(so) && !$past(cs_n)) |-> ($past(sck_d) && !$past(sck) && $past(hold_n)));

    // R11: the bit position is frozen while hold is low
    a_r11_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (!hold_n && !cs_n) |=> $stable(bit_cnt));

    // R4: a program cycle needs the write-enable latch
    a_r4_start_needs_wel: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel));

    // R5: a program cycle needs write-protect released
    a_r5_start_needs_wp: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wp_n));

    // R12: a cycle starts only on deselect after a whole byte
    a_r12_start_aligned: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(cs_n) && $past(bit_cnt) == 3'd0));

    // R8: the latch is clear when the cycle ends
    a_r8_wel_clear_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    // R8: busy lasts exactly the programmed number of clocks
    a_r8_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == PROG_CYCLES));

    // R9: the latch cannot be set during a cycle
    a_r9_no_wel_in_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> !$rose(wel));
endmodule

bind spi_ee_ctrl spi_ee_checker #(.PROG_CYCLES(PROG_CYCLES)) i_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .hold_n(hold_n), .wp_n(wp_n),
    .so(so), .sck_d(sck_d), .bit_cnt(bit_cnt), .busy(busy), .wel(wel)
);

// File: tb/test_spi_ee_ctrl.sv
module test_spi_ee_ctrl;
    localparam int AW    = 11;
    localparam int PC    = 300;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] mm [DEPTH];
    logic       m_wel = 1'b0, m_busy = 1'b0;
    logic [1:0] m_bp = 2'b00, m_bp_pend = 2'b00;
    logic       exp_en = 1'b0;

    always #10 clk = ~clk;

    spi_ee_ctrl #(.ADDR_W(AW), .PAGE_W(5), .PROG_CYCLES(PC)) i_spi_ee_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R2: per-clock reference of the output enable
    always @(posedge clk) exp_en <= !rst && !cs_n && hold_n;
    always @(negedge clk) if (!rst && !finished) chk(so_en === exp_en, "R2 so_en", so_en, exp_en);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] txq[$], input int extra, input int hold_at,
                        output logic [7:0] rxq[$]);
        logic [7:0] cur = 8'h00;
        int nbits = txq.size() * 8 + extra;
        rxq = {};
        cs_n = 1'b0;
        tick(2);
        for (int bi = 0; bi < nbits; bi++) begin
            sck = 1'b0;
            si  = (bi < txq.size() * 8) ? txq[bi / 8][7 - bi % 8] : 1'b0;
            tick(2);
            if (bi == hold_at) begin
                hold_n = 1'b0;
                tick(2);
                for (int k = 0; k < 3; k++) begin
                    sck = 1'b1; tick(2);
                    sck = 1'b0; tick(2);
                end
                chk(so_en == 1'b0, "R11 so released in hold", so_en, 0);
                hold_n = 1'b1;
                tick(2);
            end
            cur = {cur[6:0], so};
            sck = 1'b1;
            tick(2);
            if (bi % 8 == 7) rxq.push_back(cur);
        end
        sck = 1'b0;
        tick(2);
        cs_n = 1'b1;
        tick(2);
    endtask

    function automatic bit locked(input int a);
        case (m_bp)
            2'd0:    return 1'b0;
            2'd1:    return a >= DEPTH * 3 / 4;
            2'd2:    return a >= DEPTH / 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic cmd(input logic [7:0] c);
        logic [7:0] r[$];
        xfer('{c}, 0, -1, r);
        if (!m_busy && c == 8'h06) m_wel = 1'b1;
        if (!m_busy && c == 8'h04) m_wel = 1'b0;
    endtask

    task automatic wait_idle();
        tick(PC + 10);
        if (m_busy) begin
            m_busy = 1'b0;
            m_wel  = 1'b0;
            m_bp   = m_bp_pend;
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d[$], input int extra);
        logic [7:0] q[$];
        logic [7:0] r[$];
        int ea = a % DEPTH;
        q = '{8'h02, 8'(a >> 8), 8'(a)};
        foreach (d[i]) q.push_back(d[i]);
        xfer(q, extra, -1, r);
        if (m_wel && wp_n && !m_busy && extra == 0 && d.size() > 0 && !locked(ea)) begin
            foreach (d[i]) mm[(ea & ~31) + ((ea + i) & 31)] = d[i];
            m_busy = 1'b1;
        end
    endtask

    task automatic do_wrsr(input logic [7:0] v);
        logic [7:0] r[$];
        xfer('{8'h01, v}, 0, -1, r);
        if (m_wel && wp_n && !m_busy) begin
            m_bp_pend = v[3:2];
            m_busy    = 1'b1;
        end
    endtask

    task automatic rdsr_chk(input string req);
        logic [7:0] r[$];
        logic [7:0] e;
        xfer('{8'h05, 8'h00, 8'h00}, 0, -1, r);
        e = {4'b0000, m_bp, m_wel, m_busy};
        chk(r[1] == e, req, r[1], e);
        chk(r[2] == e, req, r[2], e);
    endtask

    task automatic read_chk(input int a, input int n, input int hold_at, input string req);
        logic [7:0] q[$];
        logic [7:0] r[$];
        logic [7:0] e;
        q = '{8'h03, 8'(a >> 8), 8'(a)};
        for (int i = 0; i < n; i++) q.push_back(8'h00);
        xfer(q, 0, hold_at, r);
        for (int i = 0; i < n; i++) begin
            e = m_busy ? 8'h00 : mm[(a + i) % DEPTH];
            chk(r[3 + i] == e, req, r[3 + i], e);
        end
    endtask

    initial begin
        logic [7:0] pg[$];
        tick(3);
        chk(so_en == 1'b0, "R2 reset so_en", so_en, 0);
        rst = 1'b0;
        tick(2);
        rdsr_chk("R13 reset status");

        cmd(8'h06); rdsr_chk("R3 latch set");
        cmd(8'h04); rdsr_chk("R3 latch cleared");

        cmd(8'h06); do_write(16'h0040, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}, 0);
        rdsr_chk("R8 busy during cycle");
        wait_idle(); rdsr_chk("R8 latch clear after cycle");
        read_chk(16'h0040, 4, -1, "R1 R10 read back");
        read_chk(16'hF840, 2, -1, "R4 upper address bits ignored");

        do_write(16'h0040, '{8'h55}, 0); wait_idle();
        read_chk(16'h0040, 1, -1, "R4 write without latch");

        cmd(8'h06); wp_n = 1'b0; do_write(16'h0040, '{8'h66}, 0);
        rdsr_chk("R5 no cycle with wp low"); wp_n = 1'b1;
        read_chk(16'h0040, 1, -1, "R5 array kept");
        cmd(8'h04);

        cmd(8'h06); do_write(16'h005E, '{8'hB0, 8'hB1, 8'hB2, 8'hB3}, 0); wait_idle();
        read_chk(16'h0040, 2, -1, "R7 page wrap low");
        read_chk(16'h005E, 2, -1, "R7 page top");

        cmd(8'h06); do_write(16'h0080, '{8'h5A}, 0); wait_idle();
        cmd(8'h06); do_write(16'h0080, '{8'h99}, 3);
        rdsr_chk("R12 partial byte no cycle");
        read_chk(16'h0080, 1, -1, "R12 array kept");
        cmd(8'h04);

        pg = {};
        for (int i = 0; i < 32; i++) pg.push_back(8'(i * 7 + 3));
        cmd(8'h06); do_write(16'h07E0, pg, 0); wait_idle();
        cmd(8'h06); do_write(16'h0000, '{8'hC0, 8'hC1}, 0); wait_idle();
        read_chk(16'h07FE, 4, -1, "R10 wrap to zero");

        cmd(8'h06); do_wrsr(8'h04); rdsr_chk("R14 status write busy");
        wait_idle(); rdsr_chk("R14 protect code 01");
        cmd(8'h06); do_write(16'h07E0, '{8'hEE}, 0); rdsr_chk("R6 upper quarter locked");
        read_chk(16'h07E0, 1, -1, "R6 locked byte kept");
        do_write(16'h0400, '{8'h44}, 0); wait_idle();
        read_chk(16'h0400, 1, -1, "R6 lower area writable");
        cmd(8'h06); do_wrsr(8'h08); wait_idle(); rdsr_chk("R14 protect code 10");
        cmd(8'h06); do_write(16'h0400, '{8'h45}, 0); rdsr_chk("R6 upper half locked");
        read_chk(16'h0400, 1, -1, "R6 half kept");
        do_write(16'h0100, '{8'h12}, 0); wait_idle();
        read_chk(16'h0100, 1, -1, "R6 lower half writable");
        cmd(8'h06); do_wrsr(8'h0C); wait_idle();
        cmd(8'h06); do_write(16'h0000, '{8'h77}, 0); rdsr_chk("R6 all locked");
        wp_n = 1'b0; do_wrsr(8'h00); rdsr_chk("R5 status write blocked");
        wp_n = 1'b1; do_wrsr(8'h00); wait_idle(); rdsr_chk("R14 protect cleared");

        cmd(8'h06); do_write(16'h0100, '{8'h13}, 0);
        read_chk(16'h0100, 1, -1, "R9 read ignored while busy");
        cmd(8'h06);
        wait_idle(); rdsr_chk("R9 latch not set while busy");
        read_chk(16'h0100, 1, -1, "R9 data after cycle");

        read_chk(16'h07E0, 4, 30, "R11 hold keeps position");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule